// File: doc/BRIEF.md
# Frame-synchronised serial front end for a dual 8-bit DAC

This block is the digital input side of a two-channel 8-bit digital-to-analog converter. A host shifts 16-bit words into it over a three-wire serial link: a serial clock, a data line and an active-low frame strobe. All three wires are brought into the system clock domain through two-flop synchronisers. The serial clock's rising edges are detected in that domain, and the data line is sampled on those edges.

Each word is sent most significant bit first. Its upper byte is a command and its lower byte is a sample code. The word may arrive in one continuous burst, or as two bytes with a pause between them while the strobe stays low. Nothing is committed until the strobe returns high.

At that moment the block checks that exactly 16 bits were shifted. If so, the command byte steers the update of two input latches, two output latches, a reference-select flag and two power-down flags. A frame of any other length is dropped. The output latches drive the converter codes.

Top module: `sdac_frame_rx`

## Requirements
- R1: After reset both output codes are 0, the reference select is 0 (internal) and both power-down flags are 0. Both input latches are also 0.
- R2: A frame of 16 bits sent MSB first with load mode 01 (word bits 11:10) writes the data byte (word bits 7:0) into the input latch of the addressed channel. It then copies both input latches to the output codes.
- R3: Load mode 00 writes the data byte into the addressed input latch only. Both output codes keep their values.
- R4: Load mode 10 copies both input latches to the output codes, and its data byte is ignored. Load mode 11 changes no latch.
- R5: Word bit 8 addresses the channel (0 = A, 1 = B). The input latch of the other channel is not written.
- R6: Word bit 15 is latched into the reference select on every accepted frame (1 = external reference).
- R7: Word bit 12 (channel A) and word bit 13 (channel B) are latched into the power-down flags on every accepted frame.
- R8: A frame closed after any bit count other than 16 changes no output and no latch.
- R9: Serial clock edges that occur while the frame strobe is high shift nothing and have no effect on the next frame.
- R10: A word delivered as two 8-bit groups, with a pause while the strobe stays low, has the same effect as one continuous 16-bit word.
- R11: Outputs change only in the cycle after a frame closes. While a frame is open they keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| din | input | 1 | Serial data, MSB first |
| sync_n | input | 1 | Active-low frame strobe; its rising edge commits the word |
| dac_a | output | 8 | Output latch code of channel A |
| dac_b | output | 8 | Output latch code of channel B |
| ref_ext | output | 1 | Reference select, 1 = external |
| pd_a | output | 1 | Power-down flag of channel A |
| pd_b | output | 1 | Power-down flag of channel B |

## Verification
A wrong bit count, a shifted word or a stale input latch does not show at the ports until the next frame closes. Even then it only shows when the load mode moves an input latch to the outputs. The bench therefore uses a model that follows both input latches. It compares every port a few system cycles after each strobe rise, so a bad input latch is caught at the next transfer frame, at the latest. A second comparison, taken while each frame is still open, catches outputs that change before the commit.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int CODE_W   = 8;
  localparam int WORD_W   = 2 * CODE_W;
  localparam int NCH      = 2;
  // Command field positions inside the 16-bit word
  localparam int REF_BIT  = 15;
  localparam int PDA_BIT  = 12;   // PDA_BIT+1 is channel B
  localparam int MODE_LSB = 10;
  localparam int ADDR_BIT = 8;

  typedef enum logic [1:0] {
    LD_INPUT = 2'b00,
    LD_BOTH  = 2'b01,
    LD_XFER  = 2'b10,
    LD_NONE  = 2'b11
  } load_mode_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_prev
);
  logic [WIDTH-1:0] stg [STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i <= STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q      = stg[STAGES-1];
  assign q_prev = stg[STAGES];
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_open,
  input  logic              frame_close,
  input  logic              bit_stb,
  input  logic              bit_val,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              commit
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] word_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              take;

  assign take = frame_open && bit_stb;

  always_comb begin
    word_d = word;
    cnt_d  = bit_cnt;
    if (!frame_open) begin
      cnt_d = '0;
    end else if (take) begin
      word_d = {word[WORD_W-2:0], bit_val};
      if (bit_cnt != CNT_OVER) cnt_d = bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      bit_cnt <= '0;
    end else begin
      if (take) word <= word_d;
      bit_cnt <= cnt_d;
    end
  end

  assign commit = frame_close && (bit_cnt == CNT_FULL);
endmodule

// File: rtl/sdac_latch_bank.sv
module sdac_latch_bank
  import sdac_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int NC = NCH,
  parameter int AW = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic [2*CW-1:0]        word,
  output logic [NC-1:0][CW-1:0]  codes,
  output logic                   ref_ext,
  output logic [NC-1:0]          pd
);
  logic [CW-1:0] in_q  [NC];
  logic [CW-1:0] in_d  [NC];
  logic [CW-1:0] out_q [NC];
  logic [CW-1:0] out_d [NC];
  logic          ref_d;
  logic [NC-1:0] pd_d;

  load_mode_e    mode;
  logic [AW-1:0] addr;
  logic [CW-1:0] data;
  logic          upd;

  assign mode = load_mode_e'(word[MODE_LSB +: 2]);
  assign addr = word[ADDR_BIT +: AW];
  assign data = word[CW-1:0];
  assign upd  = commit && (mode == LD_BOTH || mode == LD_XFER);

  for (genvar c = 0; c < NC; c++) begin : g_ch
    logic wr;
    assign wr       = commit && (mode == LD_INPUT || mode == LD_BOTH) && (addr == AW'(c));
    assign in_d[c]  = wr  ? data    : in_q[c];
    assign out_d[c] = upd ? in_d[c] : out_q[c];
    assign codes[c] = out_q[c];
  end

  assign ref_d = commit ? word[REF_BIT]     : ref_ext;
  assign pd_d  = commit ? word[PDA_BIT +: NC] : pd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        in_q[c]  <= '0;
        out_q[c] <= '0;
      end
      ref_ext <= 1'b0;
      pd      <= '0;
    end else if (commit) begin
      for (int c = 0; c < NC; c++) begin
        in_q[c]  <= in_d[c];
        out_q[c] <= out_d[c];
      end
      ref_ext <= ref_d;
      pd      <= pd_d;
    end
  end
endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx
  import sdac_pkg::*;
#(
  parameter int CW     = CODE_W,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          din,
  input  logic          sync_n,
  output logic [CW-1:0] dac_a,
  output logic [CW-1:0] dac_b,
  output logic          ref_ext,
  output logic          pd_a,
  output logic          pd_b
);
  localparam int WW    = 2 * CW;
  localparam int CNT_W = $clog2(WW + 2);

  logic [1:0] rst_pipe;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  logic [2:0] pin_q, pin_prev;

  sdac_sync #(.WIDTH(3), .STAGES(STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_i_n),
    .d({sync_n, din, sclk}),
    .q(pin_q), .q_prev(pin_prev)
  );

  logic frame_open, frame_close, bit_stb;
  assign bit_stb     = pin_q[0] && !pin_prev[0];
  assign frame_open  = !pin_q[2];
  assign frame_close = pin_q[2] && !pin_prev[2];

  logic [WW-1:0]    word;
  logic [CNT_W-1:0] bit_cnt;
  logic             commit;

  sdac_shift #(.WORD_W(WW), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_i_n),
    .frame_open(frame_open), .frame_close(frame_close),
    .bit_stb(bit_stb), .bit_val(pin_q[1]),
    .word(word), .bit_cnt(bit_cnt), .commit(commit)
  );

  logic [1:0][CW-1:0] codes;
  logic [1:0]         pd;

  sdac_latch_bank #(.CW(CW), .NC(2)) u_bank (
    .clk(clk), .rst_n(rst_i_n),
    .commit(commit), .word(word),
    .codes(codes), .ref_ext(ref_ext), .pd(pd)
  );

  assign dac_a = codes[0];
  assign dac_b = codes[1];
  assign pd_a  = pd[0];
  assign pd_b  = pd[1];
endmodule

// File: rtl/sdac_frame_rx_chk.sv
module sdac_frame_rx_chk
  import sdac_pkg::*;
#(
  parameter int CW    = 8,
  parameter int CNT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit,
  input logic              frame_open,
  input logic [2*CW-1:0]   word,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [CW-1:0]     dac_a,
  input logic [CW-1:0]     dac_b,
  input logic              ref_ext,
  input logic              pd_a,
  input logic              pd_b
);
  AST_OUTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit) |-> $stable({dac_a, dac_b, ref_ext, pd_a, pd_b})); // R11
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit); // R2
  AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(2 * CW + 1)); // R8
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_open && !$past(frame_open)) |-> (bit_cnt == '0)); // R9
  AST_REF_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(commit) |-> (ref_ext == $past(word[REF_BIT]))); // R6
  AST_PD_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(commit) |-> ({pd_b, pd_a} == $past(word[PDA_BIT +: 2]))); // R7
endmodule

bind sdac_frame_rx sdac_frame_rx_chk #(.CW(CW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .frame_open(frame_open),
  .word(word), .bit_cnt(bit_cnt), .dac_a(dac_a), .dac_b(dac_b),
  .ref_ext(ref_ext), .pd_a(pd_a), .pd_b(pd_b)
);

// File: tb/sdac_frame_rx_test.sv
`timescale 1ns/1ps
module sdac_frame_rx_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sclk, din, sync_n;
  logic [7:0] dac_a, dac_b;
  logic       ref_ext, pd_a, pd_b;

  int vecs = 0;
  int errs = 0;
  int cyc  = 0;

  always #2 clk = ~clk;

  sdac_frame_rx uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .din(din), .sync_n(sync_n),
    .dac_a(dac_a), .dac_b(dac_b), .ref_ext(ref_ext), .pd_a(pd_a), .pd_b(pd_b)
  );

  typedef struct packed {
    logic       ref_e;
    logic       pd_b;
    logic       pd_a;
    logic [7:0] in_b;
    logic [7:0] in_a;
    logic [7:0] out_b;
    logic [7:0] out_a;
  } mdl_t;

  mdl_t m;

  // Word layout: [15] ref, [13] pd B, [12] pd A, [11:10] mode, [8] channel, [7:0] data
  function automatic mdl_t model_step(mdl_t s, logic [15:0] w);
    mdl_t n = s;
    logic [1:0] md = w[11:10];
    n.ref_e = w[15];
    n.pd_b  = w[13];
    n.pd_a  = w[12];
    if (md == 2'b00 || md == 2'b01) begin
      if (w[8]) n.in_b = w[7:0];
      else      n.in_a = w[7:0];
    end
    if (md == 2'b01 || md == 2'b10) begin
      n.out_a = n.in_a;
      n.out_b = n.in_b;
    end
    return n;
  endfunction

  function automatic logic [15:0] mk(logic rf, logic pb, logic pa, logic [1:0] md,
                                     logic ch, logic [7:0] d);
    return {rf, 1'b0, pb, pa, md, 1'b0, ch, d};
  endfunction

  task automatic check_ports(string tag);
    logic [19:0] act, exp;
    act = {ref_ext, pd_b, pd_a, dac_b, dac_a};
    exp = {m.ref_e, m.pd_b, m.pd_a, m.out_b, m.out_a};
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual ref/pdb/pda/b/a=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic half_bit();
    repeat (3) @(negedge clk);
  endtask

  // Sends nbits of w MSB first; optional pause after the first 8 bits.
  task automatic send(logic [15:0] w, int nbits, bit split, string tag);
    sync_n = 1'b0;
    half_bit();
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      din  = (i < 16) ? w[15 - i] : 1'($urandom);
      half_bit();
      sclk = 1'b1;
      half_bit();
      if (split && i == 7) begin
        sclk = 1'b0;
        repeat (9) @(negedge clk);
      end
    end
    sclk = 1'b0;
    repeat (6) @(negedge clk);
    check_ports("R11");
    sync_n = 1'b1;
    if (nbits == 16) m = model_step(m, w);
    repeat (7) @(negedge clk);
    check_ports(tag);
  endtask

  initial begin
    void'($urandom(32'd7303));
    rst_n = 1'b0; sclk = 1'b0; din = 1'b0; sync_n = 1'b1;
    m = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_ports("R1");

    send(mk(0, 0, 0, 2'b01, 0, 8'hA5), 16, 0, "R2");
    send(mk(0, 0, 0, 2'b00, 1, 8'h3C), 16, 0, "R3");
    send(mk(0, 0, 0, 2'b10, 0, 8'hFF), 16, 0, "R4");
    send(mk(0, 0, 0, 2'b00, 0, 8'h11), 16, 0, "R5");
    send(mk(0, 0, 0, 2'b10, 1, 8'h00), 16, 0, "R5");
    send(mk(1, 0, 0, 2'b11, 0, 8'h77), 16, 0, "R6");
    send(mk(0, 0, 0, 2'b11, 1, 8'h77), 16, 0, "R6");
    send(mk(0, 1, 0, 2'b11, 0, 8'h00), 16, 0, "R7");
    send(mk(0, 0, 1, 2'b11, 0, 8'h00), 16, 0, "R7");
    send(mk(1, 1, 1, 2'b01, 1, 8'hEE), 15, 0, "R8");
    send(mk(1, 1, 1, 2'b01, 0, 8'hEE), 17, 0, "R8");

    // Serial clock activity with the strobe high, then a clean frame.
    for (int i = 0; i < 5; i++) begin
      din = 1'b1; sclk = 1'b1; half_bit();
      sclk = 1'b0; half_bit();
    end
    check_ports("R9");
    send(mk(0, 0, 0, 2'b01, 1, 8'h5A), 16, 0, "R9");
    send(mk(1, 0, 1, 2'b01, 0, 8'hC3), 16, 1, "R10");

    for (int k = 0; k < 200; k++) begin
      logic [15:0] w = 16'($urandom);
      int r = $urandom_range(0, 9);
      int nb = (r == 0) ? $urandom_range(1, 15) : (r == 1) ? $urandom_range(17, 20) : 16;
      send(w, nb, bit'($urandom_range(0, 1)), (nb == 16) ? "R2" : "R8");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errs++;
      $display("FAIL watchdog: actual cycles=%0d expected < %0d", cyc, 150000);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule